// File: doc/BRIEF.md
# Counted Loop Branch Unit

This block chooses the next instruction address for a small sequencer that has two control-transfer instructions: an unconditional relative jump and a counted loop. Every instruction reports its own address, its length in bytes, a two-bit class and a signed byte displacement. The unit first forms the fall-through address, which is the instruction's address plus its length. A branch target is that fall-through address plus the sign-extended displacement, so a displacement reaches from 128 bytes back to 127 bytes forward of the following instruction.

The unit holds a 32-bit iteration counter. A loop instruction decrements the counter and then tests the result. A nonzero result sends control to the target. A zero result lets control fall through. Because the decrement happens before the test, a loop entered with the counter at zero wraps to all ones and runs 2^32 times. A separate load port writes the counter directly, for example when code sets up a loop. The next address, the taken flag and the counter value are all registered outputs. They show the effect of an instruction one clock after it is presented.

Top module: `cntloop_nip_unit`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears next_ip_o, taken_o and count_o to zero.
- R2: An accepted instruction (instr_valid_i high) of class 2'b00 (sequential) or class 2'b11 (reserved) sets next_ip_o to cur_ip_i + instr_len_i on the next edge and clears taken_o. The counter is unchanged.
- R3: An accepted instruction of class 2'b01 (jump) always sets next_ip_o to the target cur_ip_i + instr_len_i + sign-extended rel_off_i and sets taken_o. The counter is unchanged.
- R4: rel_off_i is an 8-bit two's-complement value applied to the following instruction's address. With the next instruction at 0x0E (0x0C plus length 2) and an offset of 0xFC, the target is 0x0A. Offset 0x80 moves 128 bytes back and 0x7F moves 127 bytes forward.
- R5: An accepted instruction of class 2'b10 (loop) writes count_o - 1 into the counter. If that value is nonzero, next_ip_o becomes the target and taken_o is set. If it is zero, next_ip_o becomes the fall-through address and taken_o is cleared.
- R6: A loop instruction executed with the counter at zero leaves the counter at 0xFFFFFFFF and is taken.
- R7: When cnt_load_i is high, the counter takes cnt_load_val_i on the next edge. This load wins over a loop decrement in the same cycle. That loop's branch decision still uses the decremented old count.
- R8: With instr_valid_i low, next_ip_o holds its value and taken_o is low. Without a load, count_o also holds.
- R9: Address arithmetic wraps modulo 2^32, in both the forward and the backward direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | An instruction is presented this cycle |
| cur_ip_i | input | 32 | Address of the presented instruction |
| instr_len_i | input | 4 | Length of the presented instruction in bytes |
| op_class_i | input | 2 | 00 sequential, 01 jump, 10 loop, 11 reserved (acts as sequential) |
| rel_off_i | input | 8 | Signed displacement from the following instruction |
| cnt_load_i | input | 1 | Write the counter |
| cnt_load_val_i | input | 32 | Value written to the counter |
| next_ip_o | output | 32 | Registered next instruction address |
| taken_o | output | 1 | Registered: the last accepted instruction transferred control |
| count_o | output | 32 | Current counter value |

## Verification
The embedded properties check the following on every cycle: that the counter holds, decrements by one or loads with load taking priority; that jumps always set the taken flag; that sequential and reserved classes never set it; that idle cycles freeze the address; and that a loop seen with a count of one exits to the fall-through address. The exact target arithmetic cannot be seen from those local relations. The bench scenarios show it: sign extension at both limits of the displacement, wrap of the address space, the worked 0x0E/0xFC example, the zero-count wrap, and a full three-pass loop ending in a fall-through.

// File: rtl/cntloop_pkg.sv
package cntloop_pkg;

    typedef enum logic [1:0] {
        OPC_SEQ  = 2'b00,
        OPC_JUMP = 2'b01,
        OPC_LOOP = 2'b10,
        OPC_RSVD = 2'b11
    } opc_e;

endpackage

// File: rtl/nip_target_calc.sv
module nip_target_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 8,
    parameter int LEN_W  = 4
) (
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [LEN_W-1:0]  len,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] fall_ip,
    output logic [ADDR_W-1:0] target_ip
);

    localparam int LEN_PAD = ADDR_W - LEN_W;
    localparam int OFF_PAD = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] len_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        len_ext   = {{LEN_PAD{1'b0}}, len};
        // displacement is two's complement: replicate its top bit
        off_ext   = {{OFF_PAD{off[OFF_W-1]}}, off};
        fall_ip   = cur_ip + len_ext;
        target_ip = fall_ip + off_ext;
    end

endmodule

// File: rtl/loop_counter.sv
module loop_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] dec_val,
    output logic             dec_nonzero
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        dec_val     = st_q.cnt - CNT_W'(1);
        dec_nonzero = |dec_val;
        st_d        = st_q;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (dec_en) begin
            st_d.cnt = dec_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.cnt;

    AST_CNT_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count_q == $past(load_val)); // R7

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !load_en) |=> count_q == $past(count_q) - CNT_W'(1)); // R5

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!dec_en && !load_en) |=> $stable(count_q)); // R8

endmodule

// File: rtl/cntloop_nip_unit.sv
module cntloop_nip_unit #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int OFF_W  = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid_i,
    input  logic [ADDR_W-1:0] cur_ip_i,
    input  logic [LEN_W-1:0]  instr_len_i,
    input  logic [1:0]        op_class_i,
    input  logic [OFF_W-1:0]  rel_off_i,
    input  logic              cnt_load_i,
    input  logic [CNT_W-1:0]  cnt_load_val_i,
    output logic [ADDR_W-1:0] next_ip_o,
    output logic              taken_o,
    output logic [CNT_W-1:0]  count_o
);

    import cntloop_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] ip;
        logic              taken;
    } nip_state_t;

    nip_state_t st_d, st_q;

    opc_e              opc;
    logic [ADDR_W-1:0] fall_ip;
    logic [ADDR_W-1:0] target_ip;
    logic              loop_dec;
    logic [CNT_W-1:0]  cnt_dec_val;
    logic              cnt_dec_nz;
    logic [CNT_W-1:0]  cnt_q;

    assign opc      = opc_e'(op_class_i);
    assign loop_dec = instr_valid_i && (opc == OPC_LOOP);

    nip_target_calc #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LEN_W  (LEN_W)
    ) tgt_i (
        .cur_ip    (cur_ip_i),
        .len       (instr_len_i),
        .off       (rel_off_i),
        .fall_ip   (fall_ip),
        .target_ip (target_ip)
    );

    loop_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .dec_en      (loop_dec),
        .load_en     (cnt_load_i),
        .load_val    (cnt_load_val_i),
        .count_q     (cnt_q),
        .dec_val     (cnt_dec_val),
        .dec_nonzero (cnt_dec_nz)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (instr_valid_i) begin
            unique case (opc)
                OPC_JUMP: begin
                    st_d.ip    = target_ip;
                    st_d.taken = 1'b1;
                end
                OPC_LOOP: begin
                    // decrement first, then test the decremented value
                    st_d.ip    = cnt_dec_nz ? target_ip : fall_ip;
                    st_d.taken = cnt_dec_nz;
                end
                default: begin
                    st_d.ip    = fall_ip;
                    st_d.taken = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_ip_o = st_q.ip;
    assign taken_o   = st_q.taken;
    assign count_o   = cnt_q;

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !instr_valid_i |=> (!taken_o && $stable(next_ip_o))); // R8

    AST_JUMP_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && op_class_i == 2'b01) |=> taken_o); // R3

    AST_SEQ_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && (op_class_i == 2'b00 || op_class_i == 2'b11)) |=> !taken_o); // R2

    AST_LOOP_LAST_PASS_EXITS: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && op_class_i == 2'b10 && count_o == CNT_W'(1))
        |=> (!taken_o && next_ip_o == $past(cur_ip_i) + ADDR_W'($past(instr_len_i)))); // R5

    AST_LOOP_ZERO_WRAPS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && op_class_i == 2'b10 && count_o == '0) |=> taken_o); // R6

endmodule

// File: tb/cntloop_nip_unit_tb_top.sv
module cntloop_nip_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid_i = 1'b0;
    logic [31:0] cur_ip_i = '0;
    logic [3:0]  instr_len_i = '0;
    logic [1:0]  op_class_i = '0;
    logic [7:0]  rel_off_i = '0;
    logic        cnt_load_i = 1'b0;
    logic [31:0] cnt_load_val_i = '0;
    logic [31:0] next_ip_o;
    logic        taken_o;
    logic [31:0] count_o;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    longint unsigned m_ip    = 0;
    bit              m_taken = 0;
    longint unsigned m_cnt   = 0;

    always #5 clk = ~clk;

    cntloop_nip_unit dut_i (
        .clk            (clk),
        .rst            (rst),
        .instr_valid_i  (instr_valid_i),
        .cur_ip_i       (cur_ip_i),
        .instr_len_i    (instr_len_i),
        .op_class_i     (op_class_i),
        .rel_off_i      (rel_off_i),
        .cnt_load_i     (cnt_load_i),
        .cnt_load_val_i (cnt_load_val_i),
        .next_ip_o      (next_ip_o),
        .taken_o        (taken_o),
        .count_o        (count_o)
    );

    task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check(req, "next_ip", next_ip_o, m_ip);
        check(req, "taken", taken_o, m_taken);
        check(req, "count", count_o, m_cnt);
    endtask

    // drive one cycle at the falling edge, update the model, compare at the next falling edge
    task automatic step(string req, bit v, bit [1:0] cls, bit [31:0] ip, int len,
                        int off, bit ld, bit [31:0] lv);
        longint unsigned fall, tgt, dec;
        instr_valid_i  = v;
        op_class_i     = cls;
        cur_ip_i       = ip;
        instr_len_i    = 4'(len);
        rel_off_i      = 8'(off);
        cnt_load_i     = ld;
        cnt_load_val_i = lv;
        fall = (longint'(ip) + len) & 64'hFFFF_FFFF;
        tgt  = (longint'(fall) + longint'($signed(8'(off)))) & 64'hFFFF_FFFF;
        dec  = (m_cnt + 64'hFFFF_FFFF) & 64'hFFFF_FFFF;
        m_taken = 0;
        if (v) begin
            if (cls == 2'b01) begin
                m_ip = tgt; m_taken = 1;
            end else if (cls == 2'b10) begin
                m_taken = (dec != 0);
                m_ip    = m_taken ? tgt : fall;
                m_cnt   = dec;
            end else begin
                m_ip = fall;
            end
        end
        if (ld) m_cnt = lv;
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        #(20000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        // R2 sequential and reserved classes
        step("R2", 1, 2'b00, 32'h0000_1000, 3, 8'h10, 0, 0);
        step("R2", 1, 2'b11, 32'h0000_2000, 15, 8'h80, 0, 0);
        // R3 jump forward and back
        step("R3", 1, 2'b01, 32'h0000_0100, 2, 8'h20, 0, 0);
        step("R3", 1, 2'b01, 32'h0000_0100, 5, 8'hF0, 0, 0);
        // R4 worked example and both displacement limits
        step("R4", 1, 2'b01, 32'h0000_000C, 2, 8'hFC, 0, 0);
        check("R4", "example target", next_ip_o, 32'h0000_000A);
        step("R4", 1, 2'b01, 32'h0000_0400, 2, 8'h80, 0, 0);
        check("R4", "min offset", next_ip_o, 32'h0000_0382);
        step("R4", 1, 2'b01, 32'h0000_0400, 2, 8'h7F, 0, 0);
        check("R4", "max offset", next_ip_o, 32'h0000_0481);
        // R8 idle holds, and holds count
        step("R8", 0, 2'b01, 32'h0000_9999, 1, 8'h01, 0, 0);
        step("R8", 0, 2'b10, 32'h0000_9999, 1, 8'h01, 0, 0);
        // R6 zero count wraps and is taken
        step("R6", 1, 2'b10, 32'h0000_0040, 2, 8'hFC, 0, 0);
        check("R6", "wrapped count", count_o, 32'hFFFF_FFFF);
        // R7 load, then a three-pass loop (R5)
        step("R7", 0, 2'b00, 0, 0, 0, 1, 32'd3);
        step("R5", 1, 2'b10, 32'h0000_0050, 2, 8'hF8, 0, 0);
        step("R5", 1, 2'b10, 32'h0000_0050, 2, 8'hF8, 0, 0);
        step("R5", 1, 2'b10, 32'h0000_0050, 2, 8'hF8, 0, 0);
        check("R5", "loop exit taken", taken_o, 0);
        check("R5", "loop exit addr", next_ip_o, 32'h0000_0052);
        // R3 jump leaves count alone after a load
        step("R7", 0, 2'b00, 0, 0, 0, 1, 32'd7);
        step("R3", 1, 2'b01, 32'h0000_0060, 1, 8'h04, 0, 0);
        // R7 load beats decrement; branch uses decremented old count (7-1=6 -> taken)
        step("R7", 1, 2'b10, 32'h0000_0070, 2, 8'hFE, 1, 32'd1);
        check("R7", "load over decrement", count_o, 32'd1);
        // R7 with old count 1: decremented value 0 -> not taken, count loaded
        step("R7", 1, 2'b10, 32'h0000_0070, 2, 8'hFE, 1, 32'd9);
        // R9 address wrap forward and backward
        step("R9", 1, 2'b00, 32'hFFFF_FFFE, 4, 0, 0, 0);
        step("R9", 1, 2'b01, 32'hFFFF_FFF0, 2, 8'h7F, 0, 0);
        step("R9", 1, 2'b01, 32'h0000_0002, 1, 8'h80, 0, 0);
        // R1 reset again mid-run
        rst = 1'b1;
        m_ip = 0; m_taken = 0; m_cnt = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule